// File: doc/BRIEF.md
# Toggle-Handshake Serial Byte Receiver

This block takes bytes from an external sender. The sender supplies a free-running or gated shift clock and a data line. Both inputs are brought into the system clock domain through synchronisers. A data bit is captured on each rising edge of the synchronised shift clock, most significant bit first.

When a full byte has been assembled, the block moves it into a holding register. In the same step it inverts a handshake output. It does not drive a busy level for a fixed time. Each level the sender has already seen becomes the busy level for the next byte, and the flip tells the sender it may shift out another byte. Local consumer logic takes the held byte through a valid/ready pair.

A byte that completes while the holding register is still full is discarded. It sets a sticky overrun flag and does not flip the handshake. A free-running count of stored bytes lets the system detect when the two sides have drifted out of step.

Top module: `shake_byte_rx`

## Requirements
- R1: While rstN is low, and after it is released, hsOut is 0, rxValid is 0, overrun is 0 and byteCount is 0. Reset is asynchronous, so hsOut goes to 0 as soon as rstN falls.
- R2: Bits on serData are captured on rising edges of serClk, most significant bit first. After DATA_W rising edges, the assembled byte appears on rxData with rxValid high.
- R3: hsOut inverts exactly once for each byte stored into the holding register. The inversion happens in the same clock cycle that rxValid rises, before the consumer takes the byte.
- R4: While rxValid is high and rxReady is low, rxValid stays high and rxData stays unchanged. One clock cycle after a cycle with rxValid and rxReady both high, rxValid is low.
- R5: A byte that completes while rxValid is high is dropped. overrun is set and stays set until reset, hsOut does not change, rxData keeps the earlier byte and byteCount does not advance.
- R6: byteCount (CNT_W bits) rises by one for each byte stored and wraps to 0 after its maximum value.
- R7: Reset discards any partly received bits, so the first byte after reset is assembled starting from its first bit.
- R8: Changes on serData while serClk does not rise have no effect on the received bytes, rxValid or hsOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Asynchronous shift clock from the sender |
| serData | input | 1 | Asynchronous serial data from the sender |
| rxData | output | DATA_W | Held byte |
| rxValid | output | 1 | Held byte is available |
| rxReady | input | 1 | Consumer accepts the held byte |
| hsOut | output | 1 | Toggle handshake back to the sender |
| overrun | output | 1 | Sticky flag: a byte was dropped |
| byteCount | output | CNT_W | Count of stored bytes, wrapping |

## Verification
The assertions assume that each level of serClk lasts at least two system clock periods. Under that assumption the synchroniser shows every edge, and the shift register is stable in the cycle that follows byte completion. They also assume serData is steady around the rising shift-clock edge, and that serClk is low when reset is released, so that no false edge appears after reset. The bench holds each shift-clock level for three system cycles. It changes serData only while serClk is low, and it lowers serClk before every reset release.

// File: rtl/shake_rx_pkg.sv
package shake_rx_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic shiftEn;    // shift one synchronised data bit in
    logic loadHold;   // copy the shift register to the holding register
    logic bumpCount;  // advance the stored-byte counter
  } rxStrobe_t;

endpackage

// File: rtl/shake_rx_sync.sv
module shake_rx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/shake_rx_ctrl.sv
module shake_rx_ctrl
  import shake_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClkSync,
  input  logic       rxReady,
  output rxStrobe_t  strobe,
  output logic       rxValid,
  output logic       hsOut,
  output logic       overrun
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic             clkPrev;
  logic [BIT_W-1:0] bitCnt;
  logic             byteDone;
  logic             clkRise;
  logic             lastBit;
  logic             take;

  assign clkRise = serClkSync & ~clkPrev;
  assign lastBit = clkRise && (bitCnt == LAST_BIT);
  assign take    = rxValid & rxReady;

  assign strobe.shiftEn   = clkRise;
  assign strobe.loadHold  = byteDone & ~rxValid;
  assign strobe.bumpCount = byteDone & ~rxValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      rxValid  <= 1'b0;
      hsOut    <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      clkPrev  <= serClkSync;
      byteDone <= lastBit;
      if (lastBit)      bitCnt <= '0;
      else if (clkRise) bitCnt <= bitCnt + 1'b1;
      if (strobe.loadHold) begin
        rxValid <= 1'b1;
        hsOut   <= ~hsOut;
      end else if (take) begin
        rxValid <= 1'b0;
      end
      if (byteDone && rxValid) overrun <= 1'b1;
    end
  end

  // R3: the handshake only moves in the cycle a byte becomes valid
  assert_hs_with_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hsOut != $past(hsOut)) |-> (rxValid && !$past(rxValid)));

  // R5: overrun is sticky until reset
  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(overrun) |-> overrun);

  // R2: bit counter stays within one byte
  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (32'(bitCnt) < DATA_W));

endmodule

// File: rtl/shake_rx_dp.sv
module shake_rx_dp
  import shake_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serDataSync,
  input  rxStrobe_t         strobe,
  output logic [DATA_W-1:0] rxData,
  output logic [CNT_W-1:0]  byteCount
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxData    <= '0;
      byteCount <= '0;
    end else begin
      if (strobe.shiftEn)   shiftReg  <= {shiftReg[DATA_W-2:0], serDataSync};
      if (strobe.loadHold)  rxData    <= shiftReg;
      if (strobe.bumpCount) byteCount <= byteCount + 1'b1;
    end
  end

  // R6: the counter moves by exactly one step
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (byteCount != $past(byteCount)) |-> (byteCount == $past(byteCount) + 1'b1));

endmodule

// File: rtl/shake_byte_rx.sv
module shake_byte_rx
  import shake_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              hsOut,
  output logic              overrun,
  output logic [CNT_W-1:0]  byteCount
);

  logic [1:0] syncOut;
  rxStrobe_t  strobe;

  shake_rx_sync #(.STAGES(SYNC_STAGES), .W(2)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({serClk, serData}),
    .dout (syncOut)
  );

  shake_rx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .serClkSync (syncOut[1]),
    .rxReady    (rxReady),
    .strobe     (strobe),
    .rxValid    (rxValid),
    .hsOut      (hsOut),
    .overrun    (overrun)
  );

  shake_rx_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .serDataSync (syncOut[0]),
    .strobe      (strobe),
    .rxData      (rxData),
    .byteCount   (byteCount)
  );

  // R4: an untaken byte stays valid and unchanged
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  // R4: a taken byte is released on the next cycle
  assert_take_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> !rxValid);

endmodule

// File: tb/shake_byte_rx_test.sv
module shake_byte_rx_test;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b0;
  logic       serData = 1'b0;
  logic       rxReady = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       hsOut;
  logic       overrun;
  logic [7:0] byteCount;

  int tests = 0;
  int fails = 0;
  logic       expHs = 1'b0;
  logic [7:0] expCnt = 8'd0;
  bit         done = 1'b0;

  shake_byte_rx uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .hsOut(hsOut), .overrun(overrun), .byteCount(byteCount)
  );

  always #5 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendBits(logic [7:0] b, int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      @(negedge clk);
      serClk  = 1'b0;
      serData = b[i];
      repeat (HALF) @(negedge clk);
      serClk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    @(negedge clk);
    serClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic takeByte();
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
  endtask

  task automatic expectStore(string req, logic [7:0] b);
    expHs  = ~expHs;
    expCnt = expCnt + 8'd1;
    check(req, "rxValid", int'(rxValid), 1);
    check(req, "rxData", int'(rxData), int'(b));
    check("R3", "hsOut", int'(hsOut), int'(expHs));
    check("R6", "byteCount", int'(byteCount), int'(expCnt));
  endtask

  task automatic testReset();
    check("R1", "hsOut", int'(hsOut), 0);
    check("R1", "rxValid", int'(rxValid), 0);
    check("R1", "overrun", int'(overrun), 0);
    check("R1", "byteCount", int'(byteCount), 0);
  endtask

  task automatic testSingle();
    sendBits(8'hA5, 8);
    expectStore("R2", 8'hA5);
    takeByte();
    check("R4", "rxValid after take", int'(rxValid), 0);
  endtask

  task automatic testHold();
    sendBits(8'h3C, 8);
    expectStore("R2", 8'h3C);
    repeat (20) @(negedge clk);
    check("R4", "rxValid held", int'(rxValid), 1);
    check("R4", "rxData held", int'(rxData), 8'h3C);
    takeByte();
    check("R4", "rxValid released", int'(rxValid), 0);
  endtask

  task automatic testOverrun();
    sendBits(8'h81, 8);
    expectStore("R2", 8'h81);
    sendBits(8'h7E, 8);
    check("R5", "overrun", int'(overrun), 1);
    check("R5", "rxData kept", int'(rxData), 8'h81);
    check("R5", "hsOut unchanged", int'(hsOut), int'(expHs));
    check("R5", "byteCount unchanged", int'(byteCount), int'(expCnt));
    takeByte();
    sendBits(8'h55, 8);
    expectStore("R2", 8'h55);
    check("R5", "overrun sticky", int'(overrun), 1);
    takeByte();
  endtask

  task automatic testDataWiggle();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      serData = ~serData;
    end
    repeat (4) @(negedge clk);
    check("R8", "rxValid after wiggle", int'(rxValid), 0);
    check("R8", "hsOut after wiggle", int'(hsOut), int'(expHs));
    sendBits(8'hC3, 8);
    expectStore("R8", 8'hC3);
    takeByte();
  endtask

  task automatic testResetMidByte();
    sendBits(8'hF0, 3);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1", "hsOut in reset", int'(hsOut), 0);
    check("R1", "overrun in reset", int'(overrun), 0);
    check("R1", "byteCount in reset", int'(byteCount), 0);
    expHs  = 1'b0;
    expCnt = 8'd0;
    serClk = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    sendBits(8'h96, 8);
    expectStore("R7", 8'h96);
    takeByte();
  endtask

  task automatic testWrap();
    for (int n = 0; n < 256; n++) begin
      sendBits(8'(n), 8);
      expHs  = ~expHs;
      expCnt = expCnt + 8'd1;
      if (rxData != 8'(n) || !rxValid) begin
        check("R2", "burst byte", int'(rxData), n);
      end
      takeByte();
    end
    check("R6", "byteCount wrap", int'(byteCount), int'(expCnt));
    check("R3", "hsOut after burst", int'(hsOut), int'(expHs));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testSingle();
    testHold();
    testOverrun();
    testDataWiggle();
    testResetMidByte();
    testWrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule